// File: doc/BRIEF.md
# Compare-Clear Timer Channel

This block is a single 16-bit up-counter channel. An 8-bit control word picks where count pulses come from (a tap of a free-running internal divider, or a synchronized external clock pin), which edge of that pin counts, and which event returns the counter to zero. Four 16-bit general registers serve as compare values. Each time the counter is due to advance and equals one of them, the channel raises a one-cycle match flag. If that register is the chosen clear source, the counter goes to zero instead of incrementing.

Several channels can be chained. A channel whose own compare clear fires drives a one-cycle sync-clear output. A neighbour with its synchronous-operation enable set and a sync-clear code selected zeroes its counter when that pulse arrives. Registers C and D can be put in buffer mode through two input flags. While in buffer mode they neither match nor clear. Software reaches the channel only through a simple write port.

Top module: `tmr_chan`

## Requirements
- R1: After reset the counter, control word, all four general registers, the match flags, the overflow flag and the sync-clear output are zero.
- R2: The internal divider is zero after reset and advances every cycle. Prescale code (control bits [2:0]) 000, 001, 010, 011, 110, 101, 111 gives divide by 1, 4, 16, 64, 256, 1024, 4096. Code 100 selects the external pin. A divide-by-N enable occurs on the clock edges where the number of edges since reset, counted from 0, is congruent to N-1 modulo N.
- R3: The counter changes only on a count enable, a write or a sync clear. A write with wr_addr 0 loads the control word from wr_data[7:0]. Address 1 loads the counter, and this write has priority over everything else. Addresses 2 to 5 load registers A to D.
- R4: The external pin passes through two synchronizer flops before edge detection. Edge code (control bits [4:3]) 00 counts rising edges, 01 counts falling edges, and 10 or 11 counts both.
- R5: Clear code (control bits [7:5]) 001 selects register A and 010 selects register B. On a count enable where the counter equals the selected register, the counter loads zero, which gives a period of value+1 enables. Codes 000 and 100 never clear.
- R6: Clear codes 101 and 110 select registers C and D in the same way.
- R7: When buf_c (or buf_d) is high, register C (or D) produces no match flag and does not clear the counter, even when its clear code is selected.
- R8: With clear code 011 or 111 and sync_en high, a high sync_clr_in zeroes the counter at the next clock edge, whether or not a count enable is present. With sync_en low, or with any other clear code, sync_clr_in has no effect.
- R9: Counting past 0xFFFF wraps to 0x0000, and ovf is high for exactly the following cycle.
- R10: match[i] pulses for one cycle after a count enable on which the counter equaled register i (bit 0 = A … bit 3 = D). sync_clr_out pulses for one cycle after each own compare clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write target: 0 control, 1 counter, 2-5 registers A-D |
| wr_data | input | 16 | Write data |
| buf_c | input | 1 | Register C in buffer mode |
| buf_d | input | 1 | Register D in buffer mode |
| sync_en | input | 1 | Synchronous-operation enable for this channel |
| sync_clr_in | input | 1 | Sync-clear pulse from another channel |
| ext_clk | input | 1 | External count clock pin (asynchronous) |
| cnt | output | 16 | Counter value |
| match | output | 4 | Per-register match pulses (A..D) |
| ovf | output | 1 | Overflow pulse |
| sync_clr_out | output | 1 | Own compare-clear pulse for chained channels |

## Verification
On every cycle, the assertions check these invariants: the counter only moves on an enable, a write or a sync clear; an overflow or sync-clear-out pulse always leaves the counter at zero; a buffered C register never flags; and divide-by-4 and rising-edge enables never occur on two cycles in a row. Only the bench scenarios can show the exact counts for each prescale code and its irregular encoding, the period set by each clear source, the buffer-mode override of a selected clear, the three edge modes on the external pin, and the gating of sync clear by the enable and the code.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CNT_W  = 16;
  localparam int CTL_W  = 8;
  localparam int DIV_W  = 12;
  localparam int NREG   = 4;
  localparam int ADDR_W = 3;

  localparam int ADDR_CTL = 0;
  localparam int ADDR_CNT = 1;
  localparam int ADDR_GR0 = 2;

  // clear-source codes, control bits [7:5]
  localparam logic [2:0] CLR_A = 3'b001;
  localparam logic [2:0] CLR_B = 3'b010;
  localparam logic [2:0] CLR_C = 3'b101;
  localparam logic [2:0] CLR_D = 3'b110;
  localparam logic [1:0] CLR_SYNC_LO = 2'b11;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int DIV_W = tmr_pkg::DIV_W
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] psel,
  input  logic       ext_tick,
  output logic       tick
);
  localparam int NTAP = DIV_W / 2 + 1;

  logic [DIV_W-1:0] div_q, div_d;
  logic [NTAP-1:0]  tap;

  always_comb div_d = div_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  assign tap[0] = 1'b1;
  generate
    for (genvar k = 1; k < NTAP; k++) begin : g_tap
      assign tap[k] = &div_q[2*k-1:0];
    end
  endgenerate

  always_comb begin
    case (psel)
      3'd0:    tick = tap[0];
      3'd1:    tick = tap[1];
      3'd2:    tick = tap[2];
      3'd3:    tick = tap[3];
      3'd4:    tick = ext_tick;
      3'd5:    tick = tap[5];
      3'd6:    tick = tap[4];
      default: tick = tap[6];
    endcase
  end

  // R2
  div4_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (psel == 3'd1 && tick) |=> (psel != 3'd1 || !tick));
endmodule

// File: rtl/tmr_extedge.sv
module tmr_extedge (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin,
  input  logic [1:0] edge_sel,
  output logic       pulse
);
  logic s1_q, s2_q, hist_q;
  logic rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      hist_q <= 1'b0;
    end else begin
      s1_q   <= pin;
      s2_q   <= s1_q;
      hist_q <= s2_q;
    end
  end

  always_comb begin
    rise = s2_q & ~hist_q;
    fall = ~s2_q & hist_q;
    if (edge_sel[1])      pulse = rise | fall;
    else if (edge_sel[0]) pulse = fall;
    else                  pulse = rise;
  end

  // R4
  rise_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_sel == 2'b00 && pulse) |=> (edge_sel != 2'b00 || !pulse));
endmodule

// File: rtl/tmr_cmpclr.sv
module tmr_cmpclr #(
  parameter int CNT_W = tmr_pkg::CNT_W,
  parameter int NREG  = tmr_pkg::NREG
) (
  input  logic [CNT_W-1:0]           cnt,
  input  logic [NREG-1:0][CNT_W-1:0] gr,
  input  logic                       cnt_en,
  input  logic [2:0]                 clr_sel,
  input  logic                       buf_c,
  input  logic                       buf_d,
  output logic [NREG-1:0]            hit,
  output logic                       clr_hit
);
  import tmr_pkg::*;

  logic [NREG-1:0] bmask;
  assign bmask = {buf_d, buf_c, {(NREG-2){1'b0}}};

  generate
    for (genvar i = 0; i < NREG; i++) begin : g_cmp
      assign hit[i] = cnt_en & (cnt == gr[i]) & ~bmask[i];
    end
  endgenerate

  always_comb begin
    case (clr_sel)
      CLR_A:   clr_hit = hit[0];
      CLR_B:   clr_hit = hit[1];
      CLR_C:   clr_hit = hit[2];
      CLR_D:   clr_hit = hit[3];
      default: clr_hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan #(
  parameter int CNT_W  = tmr_pkg::CNT_W,
  parameter int CTL_W  = tmr_pkg::CTL_W,
  parameter int DIV_W  = tmr_pkg::DIV_W,
  parameter int NREG   = tmr_pkg::NREG,
  parameter int ADDR_W = tmr_pkg::ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              buf_c,
  input  logic              buf_d,
  input  logic              sync_en,
  input  logic              sync_clr_in,
  input  logic              ext_clk,
  output logic [CNT_W-1:0]  cnt,
  output logic [NREG-1:0]   match,
  output logic              ovf,
  output logic              sync_clr_out
);
  import tmr_pkg::*;

  logic [CTL_W-1:0]           ctl_q, ctl_d;
  logic [NREG-1:0][CNT_W-1:0] gr_q, gr_d;
  logic [CNT_W-1:0]           cnt_q, cnt_d;
  logic [NREG-1:0]            match_q, match_d;
  logic                       ovf_q, ovf_d, sclr_q, sclr_d;
  logic                       ext_tick, cnt_en, clr_hit, cnt_wr, sync_take;
  logic [NREG-1:0]            hit;
  logic [2:0]                 clr_sel;
  logic [1:0]                 edge_sel;
  logic [2:0]                 psel;

  assign clr_sel  = ctl_q[7:5];
  assign edge_sel = ctl_q[4:3];
  assign psel     = ctl_q[2:0];

  tmr_extedge u_edge (
    .clk(clk), .rst_n(rst_n), .pin(ext_clk), .edge_sel(edge_sel), .pulse(ext_tick)
  );

  tmr_prescale #(.DIV_W(DIV_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .psel(psel), .ext_tick(ext_tick), .tick(cnt_en)
  );

  tmr_cmpclr #(.CNT_W(CNT_W), .NREG(NREG)) u_cmp (
    .cnt(cnt_q), .gr(gr_q), .cnt_en(cnt_en), .clr_sel(clr_sel),
    .buf_c(buf_c), .buf_d(buf_d), .hit(hit), .clr_hit(clr_hit)
  );

  always_comb begin
    ctl_d     = ctl_q;
    gr_d      = gr_q;
    cnt_wr    = wr_en && (int'(wr_addr) == ADDR_CNT);
    sync_take = sync_en && (clr_sel[1:0] == CLR_SYNC_LO) && sync_clr_in;
    if (wr_en && int'(wr_addr) == ADDR_CTL) ctl_d = wr_data[CTL_W-1:0];
    for (int i = 0; i < NREG; i++) begin
      if (wr_en && int'(wr_addr) == ADDR_GR0 + i) gr_d[i] = wr_data;
    end
    if (cnt_wr)         cnt_d = wr_data;
    else if (sync_take) cnt_d = '0;
    else if (cnt_en)    cnt_d = clr_hit ? '0 : cnt_q + 1'b1;
    else                cnt_d = cnt_q;
    ovf_d   = cnt_en & ~cnt_wr & ~sync_take & ~clr_hit & (&cnt_q);
    match_d = hit;
    sclr_d  = clr_hit & ~cnt_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= '0;
      gr_q    <= '0;
      cnt_q   <= '0;
      match_q <= '0;
      ovf_q   <= 1'b0;
      sclr_q  <= 1'b0;
    end else begin
      ctl_q   <= ctl_d;
      gr_q    <= gr_d;
      cnt_q   <= cnt_d;
      match_q <= match_d;
      ovf_q   <= ovf_d;
      sclr_q  <= sclr_d;
    end
  end

  assign cnt          = cnt_q;
  assign match        = match_q;
  assign ovf          = ovf_q;
  assign sync_clr_out = sclr_q;

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_wr && !sync_take && !cnt_en) |=> $stable(cnt_q));
  // R9
  ovf_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> (cnt_q == '0));
  // R10
  sclr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclr_q |-> (cnt_q == '0));
  // R7
  bufc_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_c |=> !match_q[2]);
endmodule

// File: tb/tmr_chan_tb_top.sv
module tmr_chan_tb_top;
  logic        clk = 1'b0;
  logic        rst_n, wr_en, buf_c, buf_d, sync_en, sync_clr_in, ext_clk;
  logic [2:0]  wr_addr;
  logic [15:0] wr_data, cnt;
  logic [3:0]  match;
  logic        ovf, sync_clr_out;
  int          n_chk = 0;
  int          n_fail = 0;

  always #4 clk = ~clk;

  tmr_chan dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .buf_c(buf_c), .buf_d(buf_d), .sync_en(sync_en), .sync_clr_in(sync_clr_in),
    .ext_clk(ext_clk), .cnt(cnt), .match(match), .ovf(ovf), .sync_clr_out(sync_clr_out)
  );

  // {ctl, A, B, C, D, buf_c, buf_d, cycles, expected count}
  localparam int NV = 14;
  localparam logic [105:0] VT [NV] = '{
    {8'h00, 16'd0, 16'd0, 16'd0, 16'd0, 1'b0, 1'b0, 16'd10,   16'd10},
    {8'h01, 16'd0, 16'd0, 16'd0, 16'd0, 1'b0, 1'b0, 16'd20,   16'd5},
    {8'h02, 16'd0, 16'd0, 16'd0, 16'd0, 1'b0, 1'b0, 16'd40,   16'd2},
    {8'h03, 16'd0, 16'd0, 16'd0, 16'd0, 1'b0, 1'b0, 16'd130,  16'd2},
    {8'h06, 16'd0, 16'd0, 16'd0, 16'd0, 1'b0, 1'b0, 16'd300,  16'd1},
    {8'h05, 16'd0, 16'd0, 16'd0, 16'd0, 1'b0, 1'b0, 16'd1024, 16'd1},
    {8'h07, 16'd0, 16'd0, 16'd0, 16'd0, 1'b0, 1'b0, 16'd4096, 16'd1},
    {8'h20, 16'd4, 16'd0, 16'd0, 16'd0, 1'b0, 1'b0, 16'd12,   16'd2},
    {8'h40, 16'd2, 16'd6, 16'd0, 16'd0, 1'b0, 1'b0, 16'd10,   16'd3},
    {8'hA0, 16'd0, 16'd0, 16'd3, 16'd0, 1'b0, 1'b0, 16'd9,    16'd1},
    {8'hA0, 16'd0, 16'd0, 16'd3, 16'd0, 1'b1, 1'b0, 16'd9,    16'd9},
    {8'hC0, 16'd0, 16'd0, 16'd0, 16'd5, 1'b0, 1'b0, 16'd13,   16'd1},
    {8'hC0, 16'd0, 16'd0, 16'd0, 16'd5, 1'b0, 1'b1, 16'd13,   16'd13},
    {8'h80, 16'd2, 16'd0, 16'd0, 16'd0, 1'b0, 1'b0, 16'd8,    16'd8}
  };

  function automatic string vtag(int i);
    if (i < 7) return "R2";
    if (i == 9 || i == 11) return "R6";
    if (i == 10 || i == 12) return "R7";
    return "R5";
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset(logic bc, logic bd);
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    buf_c = bc; buf_d = bd; sync_en = 1'b0; sync_clr_in = 1'b0; ext_clk = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #1_500_000;
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R1 reset state
    do_reset(1'b0, 1'b0);
    chk("R1 cnt", cnt, 16'd0);
    chk("R1 match", {12'd0, match}, 16'd0);
    chk("R1 ovf", {15'd0, ovf}, 16'd0);
    chk("R1 sclr", {15'd0, sync_clr_out}, 16'd0);

    // vector table: prescale, clear sources, buffer override
    for (int i = 0; i < NV; i++) begin
      do_reset(VT[i][33], VT[i][32]);
      wr(3'd0, {8'd0, VT[i][105:98]});
      wr(3'd2, VT[i][97:82]);
      wr(3'd3, VT[i][81:66]);
      wr(3'd4, VT[i][65:50]);
      wr(3'd5, VT[i][49:34]);
      wr(3'd1, 16'd0);
      repeat (int'(VT[i][31:16])) @(negedge clk);
      chk(vtag(i), cnt, VT[i][15:0]);
    end

    // R4 external pin, three edge modes, three pulses each
    for (int m = 0; m < 3; m++) begin
      do_reset(1'b0, 1'b0);
      wr(3'd0, (m == 0) ? 16'h04 : (m == 1) ? 16'h0C : 16'h14);
      repeat (5) @(negedge clk);
      wr(3'd1, 16'd0);
      for (int p = 0; p < 3; p++) begin
        ext_clk = 1'b1; repeat (4) @(negedge clk);
        ext_clk = 1'b0; repeat (4) @(negedge clk);
      end
      repeat (5) @(negedge clk);
      chk("R4 edges", cnt, (m == 2) ? 16'd6 : 16'd3);
    end

    // R9 overflow wrap
    do_reset(1'b0, 1'b0);
    wr(3'd1, 16'hFFFF);
    chk("R9 pre", cnt, 16'hFFFF);
    @(negedge clk);
    chk("R9 wrap", cnt, 16'd0);
    chk("R9 ovf", {15'd0, ovf}, 16'd1);
    @(negedge clk);
    chk("R9 ovf one cycle", {15'd0, ovf}, 16'd0);

    // R10 match flags and sync-clear output
    do_reset(1'b0, 1'b0);
    wr(3'd0, 16'h20);
    wr(3'd2, 16'd3);
    wr(3'd1, 16'd0);
    repeat (3) @(negedge clk);
    chk("R10 cnt3", cnt, 16'd3);
    chk("R10 sclr low", {15'd0, sync_clr_out}, 16'd0);
    @(negedge clk);
    chk("R10 cleared", cnt, 16'd0);
    chk("R10 matchA", {12'd0, match}, 16'h1);
    chk("R10 sclr", {15'd0, sync_clr_out}, 16'd1);
    @(negedge clk);
    chk("R10 sclr one cycle", {15'd0, sync_clr_out}, 16'd0);
    chk("R10 matchBCD", {12'd0, match}, 16'hE);

    // R8 sync clear in
    do_reset(1'b0, 1'b0);
    wr(3'd0, 16'h60);
    sync_en = 1'b1;
    wr(3'd1, 16'd0);
    repeat (5) @(negedge clk);
    sync_clr_in = 1'b1;
    @(negedge clk);
    sync_clr_in = 1'b0;
    chk("R8 code011", cnt, 16'd0);
    wr(3'd0, 16'hE0);
    sync_clr_in = 1'b1;
    @(negedge clk);
    sync_clr_in = 1'b0;
    chk("R8 code111", cnt, 16'd0);
    sync_en = 1'b0;
    wr(3'd1, 16'd7);
    sync_clr_in = 1'b1;
    @(negedge clk);
    sync_clr_in = 1'b0;
    chk("R8 sync_en low ignored", cnt, 16'd8);
    sync_en = 1'b1;
    wr(3'd0, 16'h00);
    wr(3'd1, 16'd7);
    sync_clr_in = 1'b1;
    @(negedge clk);
    sync_clr_in = 1'b0;
    chk("R8 other code ignored", cnt, 16'd8);

    // R3 counter write priority over prescaled hold
    wr(3'd0, 16'h07);
    wr(3'd1, 16'h1234);
    repeat (3) @(negedge clk);
    chk("R3 write holds", cnt, 16'h1234);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule